// File: doc/BRIEF.md
# Linear Carrier Mixer with Floating Output Encoder

This block collects the carrier outputs that a time-multiplexed FM synthesis engine produces one slot at a time. It adds them into a single wide linear register. Each addition saturates at the register limits and never wraps. The register is held in offset binary. A start-of-sample strobe marks the boundary between sample periods. On that strobe the total of the period just ended is turned into a compact floating word and presented with a one-cycle valid pulse. In the same cycle the register restarts for the new period.

The floating word has a 3-bit exponent above a 10-bit mantissa, and the mantissa carries its sign in offset binary. The exponent is found by counting how many bits below the sign merely repeat it. The mantissa is the 10-bit window of the sum that starts at bit position "exponent". Low-order bits below that window are dropped. The exponent is capped so that the window never leaves the 16-bit sum.

A small state machine controls the block and has two states. `ST_IDLE` is the state after reset, when no period has started yet. `ST_ACCUM` is the state in which a period is being summed. The transition *start* (`ST_IDLE` to `ST_ACCUM`) fires on the first strobe and emits no word. The transition *emit* (`ST_ACCUM` to `ST_ACCUM`) fires on every later strobe and outputs the finished total.

Top module: `carrier_mix_fpenc`

## Requirements
- R1: After reset `out_valid` is 0 and `out_word` is 0.
- R2: The word emitted for a period encodes the saturating sum of every `car_data` value that had `car_valid` high during that period.
- R3: The running sum clamps at +32767 and at -32768 instead of wrapping.
- R4: `out_valid` is high for exactly the one cycle after each strobe taken in `ST_ACCUM`. It stays low after the first strobe following reset and on every other cycle.
- R5: `out_word[12:10]` holds the exponent e = 6 - min(r, 6). Here r counts the bits below bit 15 of the sum that equal bit 15, scanning downward until the first bit that differs.
- R6: `out_word[9:0]` holds bits [e+9:e] of the two's-complement sum, with bit 9 inverted (offset binary: 0x200 means zero).
- R7: Rebuilding the value as the signed mantissa times 2^e leaves an error that is at least 0 and less than 2^e.
- R8: A `car_data` value presented while `car_valid` is low does not change the sum.
- R9: A carrier that is valid in the same cycle as the strobe counts toward the new period, not the one being emitted.
- R10: The emitted exponent never exceeds 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_start | input | 1 | One-cycle strobe that marks a sample-period boundary |
| car_valid | input | 1 | `car_data` carries a carrier slot this cycle |
| car_data | input | 16 | Signed two's-complement carrier output |
| out_word | output | 13 | Exponent in bits [12:10], offset-binary mantissa in bits [9:0] |
| out_valid | output | 1 | One-cycle pulse when `out_word` is new |

## Verification
The pulse-width assertion assumes that two strobes are never in adjacent cycles, so every period lasts at least two cycles. The stimulus always places at least one slot cycle between strobes. The saturation and hold properties read the offset-binary register directly, and they assume that `car_data` is a two's-complement value whose top bit is the sign. Random periods draw small, large and mixed amplitudes from a fixed seed, and directed periods hit the clamp limits and the window boundaries at ±512.

// File: rtl/cmix_pkg.sv
package cmix_pkg;
    localparam int ACC_W_DEF  = 16;
    localparam int MANT_W_DEF = 10;
    localparam int EXP_W_DEF  = 3;
    localparam int CAR_W_DEF  = 16;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ACCUM = 1'b1
    } cmix_state_e;
endpackage

// File: rtl/cmix_accum.sv
module cmix_accum #(
    parameter int ACC_W = cmix_pkg::ACC_W_DEF,
    parameter int CAR_W = cmix_pkg::CAR_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [CAR_W-1:0] car_data,
    output logic [ACC_W-1:0] acc_ob
);
    localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};
    localparam int               EXT_W   = ACC_W + 1 - CAR_W;

    logic [ACC_W-1:0] cur_tc;
    logic [ACC_W-1:0] base_tc;
    logic [ACC_W:0]   sum_ext;
    logic [ACC_W-1:0] clamp_tc;
    logic [ACC_W-1:0] next_tc;

    always_comb begin
        cur_tc  = {~acc_ob[ACC_W-1], acc_ob[ACC_W-2:0]};
        base_tc = clear ? '0 : cur_tc;
        sum_ext = {base_tc[ACC_W-1], base_tc}
                + {{EXT_W{car_data[CAR_W-1]}}, car_data};
        if (sum_ext[ACC_W] != sum_ext[ACC_W-1]) begin
            clamp_tc = sum_ext[ACC_W] ? NEG_LIM : POS_LIM;
        end else begin
            clamp_tc = sum_ext[ACC_W-1:0];
        end
        next_tc = add_en ? clamp_tc : base_tc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_ob <= {1'b1, {(ACC_W-1){1'b0}}};
        end else begin
            acc_ob <= {~next_tc[ACC_W-1], next_tc[ACC_W-2:0]};
        end
    end
endmodule

// File: rtl/cmix_fpenc.sv
module cmix_fpenc #(
    parameter int ACC_W  = cmix_pkg::ACC_W_DEF,
    parameter int MANT_W = cmix_pkg::MANT_W_DEF,
    parameter int EXP_W  = cmix_pkg::EXP_W_DEF
) (
    input  logic [ACC_W-1:0]       acc_ob,
    output logic [EXP_W+MANT_W-1:0] word
);
    localparam int MAX_EXP = ACC_W - MANT_W;

    logic [ACC_W-1:0]  val_tc;
    logic [MANT_W-1:0] win [0:MAX_EXP];
    logic [EXP_W-1:0]  exp_sel;
    logic [MANT_W-1:0] mant_tc;
    int                red;
    logic              stop;

    assign val_tc = {~acc_ob[ACC_W-1], acc_ob[ACC_W-2:0]};

    for (genvar g = 0; g <= MAX_EXP; g++) begin : g_win
        assign win[g] = val_tc[g+MANT_W-1:g];
    end

    always_comb begin
        red  = 0;
        stop = 1'b0;
        for (int i = ACC_W - 2; i >= 0; i--) begin
            if (!stop && (val_tc[i] == val_tc[ACC_W-1])) begin
                red = red + 1;
            end else begin
                stop = 1'b1;
            end
        end
        if (red >= MAX_EXP) begin
            exp_sel = '0;
        end else begin
            exp_sel = EXP_W'(MAX_EXP - red);
        end
    end

    always_comb begin
        mant_tc = win[0];
        for (int k = 1; k <= MAX_EXP; k++) begin
            if (exp_sel == EXP_W'(k)) begin
                mant_tc = win[k];
            end
        end
    end

    assign word = {exp_sel, ~mant_tc[MANT_W-1], mant_tc[MANT_W-2:0]};
endmodule

// File: rtl/carrier_mix_fpenc.sv
module carrier_mix_fpenc #(
    parameter int ACC_W  = cmix_pkg::ACC_W_DEF,
    parameter int MANT_W = cmix_pkg::MANT_W_DEF,
    parameter int EXP_W  = cmix_pkg::EXP_W_DEF,
    parameter int CAR_W  = cmix_pkg::CAR_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_start,
    input  logic                    car_valid,
    input  logic [CAR_W-1:0]        car_data,
    output logic [EXP_W+MANT_W-1:0] out_word,
    output logic                    out_valid
);
    import cmix_pkg::*;

    localparam int WORD_W = EXP_W + MANT_W;

    cmix_state_e        state_q;
    cmix_state_e        state_d;
    logic               emit;
    logic               add_en;
    logic [ACC_W-1:0]   acc_ob;
    logic [WORD_W-1:0]  enc_word;

    always_comb begin
        state_d = state_q;
        emit    = 1'b0;
        add_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sample_start) begin
                    state_d = ST_ACCUM;
                    add_en  = car_valid;
                end
            end
            ST_ACCUM: begin
                emit   = sample_start;
                add_en = car_valid;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_word <= enc_word;
            end
        end
    end

    cmix_accum #(.ACC_W(ACC_W), .CAR_W(CAR_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sample_start),
        .add_en   (add_en),
        .car_data (car_data),
        .acc_ob   (acc_ob)
    );

    cmix_fpenc #(.ACC_W(ACC_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_enc (
        .acc_ob (acc_ob),
        .word   (enc_word)
    );
endmodule

// File: rtl/cmix_checker.sv
module cmix_checker #(
    parameter int ACC_W  = cmix_pkg::ACC_W_DEF,
    parameter int MANT_W = cmix_pkg::MANT_W_DEF,
    parameter int EXP_W  = cmix_pkg::EXP_W_DEF,
    parameter int CAR_W  = cmix_pkg::CAR_W_DEF
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample_start,
    input logic                    car_valid,
    input logic [CAR_W-1:0]        car_data,
    input logic [ACC_W-1:0]        acc_ob,
    input logic [EXP_W+MANT_W-1:0] out_word,
    input logic                    out_valid
);
    localparam int MAX_EXP = ACC_W - MANT_W;
    localparam int EXP_LO  = MANT_W;

    AST_EXP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word[EXP_LO+EXP_W-1:EXP_LO] <= EXP_W'(MAX_EXP))); // R10

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R4

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(sample_start)); // R4

    AST_MANT_NORM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_word[EXP_LO+EXP_W-1:EXP_LO] != '0))
            |-> (out_word[MANT_W-1] == out_word[MANT_W-2])); // R5

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_start && car_valid && !car_data[CAR_W-1] && (&acc_ob))
            |=> (&acc_ob)); // R3

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_start && car_valid && car_data[CAR_W-1] && (acc_ob == '0))
            |=> (acc_ob == '0)); // R3

    AST_HOLD_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_start && !car_valid) |=> $stable(acc_ob)); // R8
endmodule

bind carrier_mix_fpenc cmix_checker #(
    .ACC_W(ACC_W), .MANT_W(MANT_W), .EXP_W(EXP_W), .CAR_W(CAR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_start (sample_start),
    .car_valid    (car_valid),
    .car_data     (car_data),
    .acc_ob       (acc_ob),
    .out_word     (out_word),
    .out_valid    (out_valid)
);

// File: tb/sim_carrier_mix_fpenc.sv
module sim_carrier_mix_fpenc;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_start = 1'b0;
    logic        car_valid = 1'b0;
    logic [15:0] car_data = '0;
    logic [12:0] out_word;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    int model = 0;
    bit in_period = 0;

    always #(CLK_P/2) clk = ~clk;

    carrier_mix_fpenc u0 (
        .clk(clk), .rst_n(rst_n), .sample_start(sample_start),
        .car_valid(car_valid), .car_data(car_data),
        .out_word(out_word), .out_valid(out_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int exp_of(input int v);
        for (int e = 0; e < 6; e++) begin
            if (v >= -(512 << e) && v < (512 << e)) return e;
        end
        return 6;
    endfunction

    function automatic int enc(input int v);
        int e;
        int m;
        e = exp_of(v);
        m = v >>> e;
        return (e << 10) | ((m & 32'h3FF) ^ 32'h200);
    endfunction

    task automatic check_word(input int v);
        int w;
        int e;
        int m;
        int err;
        w = int'(out_word);
        e = (w >> 10) & 7;
        m = ((w & 32'h3FF) ^ 32'h200);
        if (m >= 512) m = m - 1024;
        err = v - m * (1 << e);
        check(out_valid === 1'b1, "R4 valid after strobe", int'(out_valid), 1);
        check(w == enc(v), "R2 word", w, enc(v));
        check(e == exp_of(v), "R5 exponent", e, exp_of(v));
        check((w & 32'h3FF) == (enc(v) & 32'h3FF), "R6 mantissa", w & 32'h3FF, enc(v) & 32'h3FF);
        check(err >= 0 && err < (1 << e), "R7 rebuild error", err, 0);
        check(e <= 6, "R10 exponent cap", e, 6);
    endtask

    task automatic step(input bit st, input bit v, input int d);
        bit chk;
        int prev;
        chk  = st && in_period;
        prev = model;
        if (st) begin
            model = v ? d : 0;
            in_period = 1;
        end else if (v) begin
            model = sat16(model + d);
        end
        sample_start = st;
        car_valid    = v;
        car_data     = 16'(d);
        @(negedge clk);
        if (chk) check_word(prev);
        else check(out_valid === 1'b0, "R4 no pulse", int'(out_valid), 0);
    endtask

    task automatic rand_period(input int mode);
        int d;
        int amp;
        step(1'b1, 1'b0, 0);
        for (int s = 0; s < 18; s++) begin
            amp = (mode == 0) ? 64 : (mode == 1) ? 8192 : (($urandom % 2) != 0 ? 64 : 8192);
            d = int'($urandom % (2 * amp)) - amp;
            step(1'b0, ($urandom % 4) != 0, d);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 valid at reset", int'(out_valid), 0);
        check(out_word === 13'd0, "R1 word at reset", int'(out_word), 0);

        // R4: first strobe after reset emits nothing (checked in step)
        step(1'b1, 1'b0, 0);
        step(1'b0, 1'b1, 5);
        // R8: invalid slots carry large data that must not count
        step(1'b0, 1'b0, 30000);
        step(1'b0, 1'b0, -30000);
        step(1'b1, 1'b0, 0);
        check(model == 0 && out_word == 13'(enc(5)), "R8 ignored slots", int'(out_word), enc(5));

        // R3: positive and negative clamp
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 16000);
        step(1'b0, 1'b1, -5);
        step(1'b1, 1'b0, 0);
        check(out_word == 13'(enc(32767 - 5)), "R3 high clamp", int'(out_word), enc(32762));
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, -16000);
        step(1'b1, 1'b0, 0);
        check(out_word == 13'h1800, "R3 low clamp", int'(out_word), 32'h1800);

        // R9: carrier in strobe cycle belongs to new period
        step(1'b0, 1'b0, 0);
        step(1'b1, 1'b1, 100);
        step(1'b0, 1'b0, 0);
        step(1'b1, 1'b0, 0);
        check(out_word == 13'(enc(100)), "R9 strobe slot", int'(out_word), enc(100));

        // Window boundaries
        step(1'b0, 1'b1, 511);   step(1'b1, 1'b0, 0);
        step(1'b0, 1'b1, 512);   step(1'b1, 1'b0, 0);
        step(1'b0, 1'b1, -512);  step(1'b1, 1'b0, 0);
        step(1'b0, 1'b1, -513);  step(1'b1, 1'b0, 0);
        step(1'b0, 1'b1, -1);    step(1'b1, 1'b0, 0);
        step(1'b0, 1'b0, 0);

        for (int p = 0; p < 60; p++) rand_period(p % 3);
        step(1'b1, 1'b0, 0);
        step(1'b0, 1'b0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule